// File: doc/BRIEF.md
# Codec power-up initialization sequencer

This block sequences a multichannel audio converter out of and back into power-down. It runs on the master clock. An active-low power-down request, `pd_n`, may arrive asynchronously. A frame clock, `lrck`, is sampled as ordinary data and is not used as a clock. While `pd_n` is low, the block holds the filter and control-register reset. It forces the converted-sample output to zero and keeps the analog outputs disabled.

Once `pd_n` goes high, the block keeps the converter in its internal power-down for a fixed number of master-clock cycles. Register writes are locked during this interval. The block then counts frame-clock rising edges. It first waits a short settling delay. It then opens two initialization windows of different lengths, one for the ADC path and one for the DAC path. Each path's data is released, and its ready flag raised, only when its own window closes.

A one-cycle mute request is issued at two moments. The first is when power-down is requested. The second is when the DAC window closes. External logic can use this request to hide switching transients.

Top module: `codec_pwrseq`

## Requirements
- R1: While the synchronized power-down request is low, `reg_rst` is 1 and `wr_lock` is 1. `pd_n` passes through a two-stage synchronizer that is cleared asynchronously while `pd_n` is low, so the sequencer enters the power-down state on the first clock edge at which `pd_n` is low.
- R2: Outside the run phase, `adc_dout` and `dac_dout` are all zeros, `aout_en` is 0, and no init or ready flag is set.
- R3: After `pd_n` rises, `reg_rst` falls on the third clock edge. `wr_lock` then stays 1 for exactly `MCLK_WAIT` further cycles (default 32768) before it falls.
- R4: After `wr_lock` falls, the first `START_DLY` frame-clock rising edges (default 3) raise no init flag. A rising edge counts three master-clock edges after it is sampled: two synchronizer stages and one edge-detect stage.
- R5: `adc_init` is 1 while the frame count is at least `START_DLY` and below `START_DLY+ADC_INIT` (default 1056). `adc_ready` is 1 from a count of `START_DLY+ADC_INIT` on. The two flags are never 1 together.
- R6: `dac_init` is 1 while the frame count is at least `START_DLY` and below `START_DLY+DAC_INIT` (default 516). `dac_ready` is 1 from the end of that window on. `aout_en` is 1 exactly when `dac_ready` is 1.
- R7: `adc_dout` equals `adc_din` when `adc_ready` is 1 and is zero otherwise. `dac_dout` equals `dac_din` when `dac_ready` is 1 and is zero otherwise.
- R8: `mute_req` is a single-cycle pulse in two cases. It fires on the edge that takes the sequencer from any state other than power-down into power-down. It also fires on the edge at which the frame count reaches `START_DLY+DAC_INIT`.
- R9: A low on `pd_n` at any point of the sequence returns the sequencer to power-down and clears all counts. The next release then repeats the full timing.
- R10: Once raised, `adc_ready` and `dac_ready` stay 1 until power-down. The frame count saturates at the larger window end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| pd_n | input | 1 | Active-low power-down request, asynchronous |
| lrck | input | 1 | Frame clock, sampled as data |
| adc_din | input | DW | Converted sample from the ADC path |
| dac_din | input | DW | Sample headed to the DAC path |
| reg_rst | output | 1 | Reset for digital filters and control registers |
| wr_lock | output | 1 | Register writes rejected while 1 |
| adc_init | output | 1 | ADC initialization window active |
| dac_init | output | 1 | DAC initialization window active |
| adc_ready | output | 1 | ADC path released |
| dac_ready | output | 1 | DAC path released |
| adc_dout | output | DW | Gated serial output sample |
| dac_dout | output | DW | Gated DAC sample |
| aout_en | output | 1 | Analog output enable (0 = high impedance) |
| mute_req | output | 1 | One-cycle mute request |

## Verification
A `pd_n` rise shows on `reg_rst` at the third clock edge. `wr_lock` follows `MCLK_WAIT` edges after that. A frame-clock rise reaches the frame count at the third master edge after it is sampled, so every init flag, ready flag and window-end mute pulse moves on that edge. A `pd_n` fall reaches the power-down state, and raises its mute pulse, on the next edge. The data outputs follow their inputs in the same cycle once the path is ready. The bench's behavioural model encodes these latencies as edge counts since release and a three-deep history of sampled frame-clock values. All outputs are compared two nanoseconds after every rising edge, and inputs change only on falling edges.

// File: rtl/codec_pwrseq_pkg.sv
package codec_pwrseq_pkg;

    typedef enum logic [1:0] {
        ST_PD   = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } seq_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/codec_pwrseq_sync.sv
module codec_pwrseq_sync #(
    parameter int STAGES = 2,
    parameter bit ACLR   = 1'b0
) (
    input  logic clk,
    input  logic clr_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    generate
        if (ACLR) begin : g_aclr
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n) sh_q <= '0;
                else        sh_q <= {sh_q[STAGES-2:0], d};
            end
        end else begin : g_plain
            logic unused_clr;
            assign unused_clr = clr_n;
            always_ff @(posedge clk) begin
                sh_q <= {sh_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/codec_pwrseq_window.sv
module codec_pwrseq_window #(
    parameter int FW    = 11,
    parameter int START = 3,
    parameter int LEN   = 1056
) (
    input  logic          run,
    input  logic [FW-1:0] fcnt,
    output logic          init,
    output logic          ready
);
    localparam int FEND = START + LEN;

    int cnt;
    assign cnt   = int'(fcnt);
    assign init  = run && (cnt >= START) && (cnt < FEND);
    assign ready = run && (cnt >= FEND);
endmodule

// File: rtl/codec_pwrseq.sv
module codec_pwrseq
    import codec_pwrseq_pkg::*;
#(
    parameter int MCLK_WAIT = 32768,
    parameter int START_DLY = 3,
    parameter int ADC_INIT  = 1056,
    parameter int DAC_INIT  = 516,
    parameter int DW        = 24
) (
    input  logic          clk,
    input  logic          pd_n,
    input  logic          lrck,
    input  logic [DW-1:0] adc_din,
    input  logic [DW-1:0] dac_din,
    output logic          reg_rst,
    output logic          wr_lock,
    output logic          adc_init,
    output logic          dac_init,
    output logic          adc_ready,
    output logic          dac_ready,
    output logic [DW-1:0] adc_dout,
    output logic [DW-1:0] dac_dout,
    output logic          aout_en,
    output logic          mute_req
);
    localparam int FMAX    = START_DLY + imax(ADC_INIT, DAC_INIT);
    localparam int DAC_END = START_DLY + DAC_INIT;
    localparam int CW      = $clog2(MCLK_WAIT + 1);
    localparam int FW      = $clog2(FMAX + 1);

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] mcnt;
        logic [FW-1:0] fcnt;
        logic          lr_prev;
        logic          mute;
    } regs_t;

    regs_t r_d, r_q;
    logic  pd_s, lr_s, lr_rise, run;

    codec_pwrseq_sync #(.STAGES(2), .ACLR(1'b1)) u_pd_sync (
        .clk   (clk),
        .clr_n (pd_n),
        .d     (1'b1),
        .q     (pd_s)
    );

    codec_pwrseq_sync #(.STAGES(2), .ACLR(1'b0)) u_lr_sync (
        .clk   (clk),
        .clr_n (1'b1),
        .d     (lrck),
        .q     (lr_s)
    );

    assign lr_rise = lr_s & ~r_q.lr_prev;

    always_comb begin
        r_d         = r_q;
        r_d.lr_prev = lr_s;
        r_d.mute    = 1'b0;
        if (!pd_s) begin
            r_d.st   = ST_PD;
            r_d.mcnt = '0;
            r_d.fcnt = '0;
            r_d.mute = (r_q.st != ST_PD);
        end else begin
            unique case (r_q.st)
                ST_PD: begin
                    r_d.st   = ST_WAIT;
                    r_d.mcnt = '0;
                end
                ST_WAIT: begin
                    if (r_q.mcnt == CW'(MCLK_WAIT - 1)) begin
                        r_d.st   = ST_RUN;
                        r_d.fcnt = '0;
                    end else begin
                        r_d.mcnt = r_q.mcnt + 1'b1;
                    end
                end
                ST_RUN: begin
                    if (lr_rise && (r_q.fcnt != FW'(FMAX))) begin
                        r_d.fcnt = r_q.fcnt + 1'b1;
                        r_d.mute = (r_q.fcnt == FW'(DAC_END - 1));
                    end
                end
                default: r_d.st = ST_PD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign run     = (r_q.st == ST_RUN);
    assign reg_rst = (r_q.st == ST_PD);
    assign wr_lock = !run;

    codec_pwrseq_window #(.FW(FW), .START(START_DLY), .LEN(ADC_INIT)) u_adc_win (
        .run   (run),
        .fcnt  (r_q.fcnt),
        .init  (adc_init),
        .ready (adc_ready)
    );

    codec_pwrseq_window #(.FW(FW), .START(START_DLY), .LEN(DAC_INIT)) u_dac_win (
        .run   (run),
        .fcnt  (r_q.fcnt),
        .init  (dac_init),
        .ready (dac_ready)
    );

    assign adc_dout = adc_ready ? adc_din : '0;
    assign dac_dout = dac_ready ? dac_din : '0;
    assign aout_en  = dac_ready;
    assign mute_req = r_q.mute;
endmodule

// File: rtl/codec_pwrseq_chk.sv
module codec_pwrseq_chk #(
    parameter int MCLK_WAIT = 32768,
    parameter int DW        = 24
) (
    input logic          clk,
    input logic          pd_n,
    input logic          reg_rst,
    input logic          wr_lock,
    input logic          adc_init,
    input logic          dac_init,
    input logic          adc_ready,
    input logic          dac_ready,
    input logic [DW-1:0] adc_dout,
    input logic [DW-1:0] dac_dout,
    input logic          aout_en,
    input logic          mute_req
);
    int wcnt;

    always_ff @(posedge clk) begin
        if (reg_rst)      wcnt <= 0;
        else if (wr_lock) wcnt <= wcnt + 1;
    end

    p_rst_locks_r1: assert property (@(posedge clk) disable iff (!pd_n)
        reg_rst |-> wr_lock);

    p_lock_len_r3: assert property (@(posedge clk) disable iff (!pd_n)
        $fell(wr_lock) |-> (wcnt == MCLK_WAIT));

    p_adc_excl_r5: assert property (@(posedge clk) disable iff (!pd_n)
        adc_init |-> (!adc_ready && !wr_lock));

    p_aout_off_r6: assert property (@(posedge clk) disable iff (!pd_n)
        dac_init |-> !aout_en);

    p_adc_zero_r7: assert property (@(posedge clk) disable iff (!pd_n)
        !adc_ready |-> (adc_dout == '0));

    p_dac_zero_r7: assert property (@(posedge clk) disable iff (!pd_n)
        !dac_ready |-> (dac_dout == '0));

    p_mute_pulse_r8: assert property (@(posedge clk) disable iff (!pd_n)
        mute_req |=> !mute_req);

    p_adc_hold_r10: assert property (@(posedge clk) disable iff (!pd_n)
        adc_ready |=> adc_ready);

    p_dac_hold_r10: assert property (@(posedge clk) disable iff (!pd_n)
        dac_ready |=> dac_ready);
endmodule

bind codec_pwrseq codec_pwrseq_chk #(.MCLK_WAIT(MCLK_WAIT), .DW(DW)) u_chk (
    .clk       (clk),
    .pd_n      (pd_n),
    .reg_rst   (reg_rst),
    .wr_lock   (wr_lock),
    .adc_init  (adc_init),
    .dac_init  (dac_init),
    .adc_ready (adc_ready),
    .dac_ready (dac_ready),
    .adc_dout  (adc_dout),
    .dac_dout  (dac_dout),
    .aout_en   (aout_en),
    .mute_req  (mute_req)
);

// File: tb/sim_codec_pwrseq.sv
`timescale 1ns/1ps
module sim_codec_pwrseq;
    localparam int MW    = 64;
    localparam int SD    = 3;
    localparam int AI    = 40;
    localparam int DI    = 20;
    localparam int DW    = 16;
    localparam int AEND  = SD + AI;
    localparam int DEND  = SD + DI;
    localparam int FMAX  = AEND;

    logic clk = 1'b0;
    logic pd_n = 1'b0;
    logic lrck = 1'b0;
    logic [DW-1:0] adc_din = '0;
    logic [DW-1:0] dac_din = '0;
    logic reg_rst, wr_lock, adc_init, dac_init, adc_ready, dac_ready, aout_en, mute_req;
    logic [DW-1:0] adc_dout, dac_dout;

    always #4 clk = ~clk;

    codec_pwrseq #(.MCLK_WAIT(MW), .START_DLY(SD), .ADC_INIT(AI), .DAC_INIT(DI), .DW(DW)) u0 (
        .clk(clk), .pd_n(pd_n), .lrck(lrck), .adc_din(adc_din), .dac_din(dac_din),
        .reg_rst(reg_rst), .wr_lock(wr_lock), .adc_init(adc_init), .dac_init(dac_init),
        .adc_ready(adc_ready), .dac_ready(dac_ready), .adc_dout(adc_dout), .dac_dout(dac_dout),
        .aout_en(aout_en), .mute_req(mute_req)
    );

    int nchk = 0, nfail = 0, ncyc = 0;
    int hi = 0, ms = 0, fc = 0;
    bit mute_m = 0;
    bit l1 = 0, l2 = 0, l3 = 0;

    task automatic chk(input string req, input string nm, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h cycle=%0d", req, nm, act, exp, ncyc);
        end
    endtask

    // Behavioural model: edges since release decide the phase, sampled
    // frame-clock history decides when a frame edge is counted.
    always @(posedge clk) begin
        int pst, pfc;
        bit rise;
        ncyc++;
        pst  = ms;
        pfc  = fc;
        rise = l2 && !l3;
        l3 = l2; l2 = l1; l1 = lrck;
        if (!pd_n) hi = 0; else if (hi < 1000000) hi++;
        ms = (hi < 3) ? 0 : (hi < 3 + MW) ? 1 : 2;
        if (ms != 2) fc = 0;
        else if (pst == 2 && rise && fc < FMAX) fc++;
        mute_m = (!pd_n && pst != 0) || (ms == 2 && fc != pfc && fc == DEND);
    end

    always @(posedge clk) begin
        bit run, ar, dr;
        #2;
        run = (ms == 2);
        ar  = run && fc >= AEND;
        dr  = run && fc >= DEND;
        chk("R1", "reg_rst", reg_rst, ms == 0);
        chk("R3", "wr_lock", wr_lock, !run);
        chk("R4/R5", "adc_init", adc_init, run && fc >= SD && fc < AEND);
        chk("R4/R6", "dac_init", dac_init, run && fc >= SD && fc < DEND);
        chk("R5", "adc_ready", adc_ready, ar);
        chk("R6", "dac_ready", dac_ready, dr);
        chk("R6", "aout_en", aout_en, dr);
        chk("R7", "adc_dout", adc_dout, ar ? adc_din : '0);
        chk("R7", "dac_dout", dac_dout, dr ? dac_din : '0);
        chk("R8", "mute_req", mute_req, mute_m);
    end

    initial begin
        forever begin
            repeat (4) @(negedge clk);
            lrck = ~lrck;
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            adc_din = adc_din + 16'h1357;
            dac_din = dac_din + 16'h0b0d;
        end
    end

    task automatic hold(input bit v, input int n);
        @(negedge clk);
        pd_n = v;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R2: power-down state with data moving at the inputs
        hold(1'b0, 12);
        // R3 R4 R5 R6 R10: full release to both ready flags
        hold(1'b1, 520);
        // R8 R9: power-down request after ready
        hold(1'b0, 6);
        // R9: abort in the middle of the DAC window
        hold(1'b1, 140);
        hold(1'b0, 4);
        // R9: abort during the master-clock wait
        hold(1'b1, 30);
        hold(1'b0, 1);
        // R1: immediate re-entry check then a clean second release
        hold(1'b1, 520);
        hold(1'b0, 5);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        wait (ncyc > 200000);
        nchk++;
        nfail++;
        $display("FAIL watchdog R9 actual=%0d expected=%0d", ncyc, 200000);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule